// File: doc/BRIEF.md
# Tiered Fault Trip Timer

This block turns a stream of differential-current measurements into a single trip decision for a ground-fault protector. Every measurement arrives as an 8-bit code that is already scaled to current, with a one-cycle valid strobe. The block places each code in one of nine severity tiers. Each tier has its own longest allowed delay, and heavier faults get shorter delays. A countdown measured in millisecond ticks then decides when the trip request is raised. A separate fast path watches a flag that reports a large raw sense voltage. If that flag stays high for longer than a short window, the trip request is raised right away.

Both the millisecond tick and the fine tick used by the fast path are expected to come from a time base locked to the mains frequency. At a lower line frequency the ticks come more slowly, so the response slows in the same proportion. Because every delay is counted in ticks, a bench can drive the ticks at any rate it likes. Once raised, the trip request stays high until a synchronous reset.

Top module: `fault_trip_timer`

## Requirements
- R1: A code below the lowest tier threshold (default 12) never starts the countdown, so such codes never raise `trip_o`, however many ticks follow.
- R2: The tier of a code is the number of thresholds that the code is equal to or above. With the defaults, the thresholds in ascending order are 12, 20, 30, 35, 40, 45, 53, 58 and 66.
- R3: The tier limits in ms ticks are 125, 95, 75, 60, 50, 40, 35, 25 and 20, for tier 1 up to tier 9. Tier 9 covers every code of 66 and above. On a fresh start, `trip_o` rises at the clock edge that samples the limit-th `ms_tick`, and it is still low after one tick fewer.
- R4: A sample in a higher tier while the countdown runs sets the remaining allowance to the smaller of the current remainder and the new tier's limit.
- R5: A sample in the same tier or a lower nonzero tier while the countdown runs leaves the remainder unchanged, so the allowance is never lengthened.
- R6: A valid sample below the lowest threshold clears the countdown and the tier. A later fault then gets its full limit again.
- R7: When `sat_flag` stays high through more than SAT_TICKS (default 14) `fine_tick` pulses, `trip_o` rises at the edge of the 15th pulse, with no tier delay. Any low cycle of `sat_flag` restarts this count.
- R8: Once `trip_o` is high, it stays high whatever the inputs, until `rst` is sampled high.
- R9: While `rst` is high at a clock edge, `trip_o` goes low and both the countdown and the saturation count are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond of mains-locked time |
| fine_tick | input | 1 | One-cycle pulse per 100 us of mains-locked time, used by the saturation window |
| sample_valid | input | 1 | Marks a new current code |
| sample_code | input | 8 | Current magnitude code |
| sat_flag | input | 1 | High while the raw sense voltage exceeds the saturation level |
| trip_o | output | 1 | Latched trip request |

## Verification
Codes are applied in the lowest tier, a middle tier and the top tier, and also just below the lowest threshold. The trip is checked one tick before the limit and again at the limit, so an off-by-one count or a wrong tier decode shows up as a trip at the wrong tick. Tier sequences are also applied while the countdown runs: a climb that must cut the remainder, a climb whose limit is larger than what remains, a drop to a lower tier that must not extend the remainder, and a sub-threshold code that must restart the countdown. Each of these needs a different trip tick to pass. The saturation flag is held for exactly the window and for one pulse longer, and it is also broken part way through, which separates "more than" from "at least" and shows whether the count restarts.

// File: rtl/fault_trip_timer.sv
module fault_trip_timer #(
  parameter int CW        = 8,
  parameter int DW        = 8,
  parameter int NT        = 9,
  parameter int SAT_TICKS = 14,
  parameter logic [CW-1:0] TIER_MIN [NT] = '{8'd12, 8'd20, 8'd30, 8'd35, 8'd40,
                                            8'd45, 8'd53, 8'd58, 8'd66},
  parameter logic [DW-1:0] TIER_DLY [NT] = '{8'd125, 8'd95, 8'd75, 8'd60, 8'd50,
                                            8'd40, 8'd35, 8'd25, 8'd20}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic          fine_tick,
  input  logic          sample_valid,
  input  logic [CW-1:0] sample_code,
  input  logic          sat_flag,
  output logic          trip_o
);
  localparam int TW = $clog2(NT + 1);
  localparam int SW = $clog2(SAT_TICKS + 1);

  logic [TW-1:0] cur_tier, tier_nx, samp_tier;
  logic [DW-1:0] remain, remain_nx, new_lim, cur_lim;
  logic [SW-1:0] sat_run, sat_nx;
  logic          fire_delay, fire_sat;

  always_comb begin
    samp_tier = '0;
    new_lim   = '0;
    cur_lim   = '0;
    for (int i = 0; i < NT; i++) begin
      if (sample_code >= TIER_MIN[i]) begin
        samp_tier = TW'(i + 1);
        new_lim   = TIER_DLY[i];
      end
      if (cur_tier == TW'(i + 1)) cur_lim = TIER_DLY[i];
    end
  end

  always_comb begin
    tier_nx   = cur_tier;
    remain_nx = remain;
    if (sample_valid) begin
      if (samp_tier == '0) begin
        tier_nx   = '0;
        remain_nx = '0;
      end else if (samp_tier > cur_tier) begin
        tier_nx = samp_tier;
        if (cur_tier == '0 || new_lim < remain) remain_nx = new_lim;
      end
    end
    fire_delay = ms_tick && (tier_nx != '0) && (remain_nx == DW'(1));
    if (ms_tick && tier_nx != '0 && remain_nx != '0) remain_nx = remain_nx - DW'(1);
  end

  assign fire_sat = sat_flag && fine_tick && (sat_run == SW'(SAT_TICKS));

  always_comb begin
    if (!sat_flag)                                     sat_nx = '0;
    else if (fine_tick && sat_run < SW'(SAT_TICKS))    sat_nx = sat_run + SW'(1);
    else                                               sat_nx = sat_run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_tier <= '0;
      remain   <= '0;
      sat_run  <= '0;
      trip_o   <= 1'b0;
    end else begin
      cur_tier <= tier_nx;
      remain   <= remain_nx;
      sat_run  <= sat_nx;
      trip_o   <= trip_o | fire_delay | fire_sat;
    end
  end

  assert_trip_latched_R8: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> trip_o);

  assert_trip_cause_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> ($past(ms_tick) || ($past(fine_tick) && $past(sat_flag))));

  assert_remain_within_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (cur_tier != '0) |-> (remain <= cur_lim));

  assert_never_lengthened_R5: assert property (@(posedge clk) disable iff (rst)
    ((cur_tier != '0) && $past(cur_tier != '0)) |-> (remain <= $past(remain)));

  assert_sat_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    sat_run <= SW'(SAT_TICKS));

  assert_clear_on_low_R6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && samp_tier == '0) |=> (cur_tier == '0 && remain == '0));
endmodule

// File: tb/fault_trip_timer_test.sv
module fault_trip_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, fine_tick = 1'b0, sample_valid = 1'b0, sat_flag = 1'b0;
  logic [7:0] sample_code = '0;
  logic trip_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_trip_timer uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .fine_tick(fine_tick),
    .sample_valid(sample_valid), .sample_code(sample_code),
    .sat_flag(sat_flag), .trip_o(trip_o)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (trip_o !== exp) begin
      errors++;
      $display("FAIL %s: trip_o=%b expected %b", req, trip_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    sat_flag = 1'b0;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk) begin sample_valid = 1'b1; sample_code = c; end
    @(negedge clk) sample_valid = 1'b0;
  endtask

  task automatic ms(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic fine(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fine_tick = 1'b1;
      @(negedge clk) fine_tick = 1'b0;
    end
  endtask

  task automatic test_reset_R9();
    do_reset();
    check("R9 reset state", 1'b0);
  endtask

  task automatic test_below_R1();
    do_reset();
    send(8'd11);
    ms(200);
    check("R1 code 11 never trips", 1'b0);
  endtask

  task automatic test_tier(input logic [7:0] c, input int lim, input string req);
    do_reset();
    send(c);
    ms(lim - 1);
    check({req, " one tick early"}, 1'b0);
    ms(1);
    check({req, " at limit"}, 1'b1);
  endtask

  task automatic test_cut_R4();
    do_reset();
    send(8'd12); ms(100); send(8'd66);
    ms(19); check("R4 cut to tier 9 early", 1'b0);
    ms(1);  check("R4 cut to tier 9 at limit", 1'b1);
    do_reset();
    send(8'd12); ms(10); send(8'd30);
    ms(74); check("R4 cut to tier 3 early", 1'b0);
    ms(1);  check("R4 cut to tier 3 at limit", 1'b1);
    do_reset();
    send(8'd20); ms(80); send(8'd30);
    ms(14); check("R4 higher tier keeps smaller remainder early", 1'b0);
    ms(1);  check("R4 higher tier keeps smaller remainder", 1'b1);
  endtask

  task automatic test_no_lengthen_R5();
    do_reset();
    send(8'd66); ms(10); send(8'd12);
    ms(9); check("R5 lower tier does not extend early", 1'b0);
    ms(1); check("R5 lower tier does not extend", 1'b1);
  endtask

  task automatic test_clear_R6();
    do_reset();
    send(8'd12); ms(100); send(8'd5); send(8'd12);
    ms(124); check("R6 restart after clear early", 1'b0);
    ms(1);   check("R6 restart after clear at limit", 1'b1);
  endtask

  task automatic test_sat_R7();
    do_reset();
    @(negedge clk) sat_flag = 1'b1;
    fine(14); check("R7 saturation window not exceeded", 1'b0);
    fine(1);  check("R7 saturation trips", 1'b1);
    do_reset();
    @(negedge clk) sat_flag = 1'b1;
    fine(14);
    @(negedge clk) sat_flag = 1'b0;
    @(negedge clk) sat_flag = 1'b1;
    fine(14); check("R7 broken saturation restarts count", 1'b0);
    fine(1);  check("R7 saturation trips after restart", 1'b1);
  endtask

  task automatic test_latch_R8();
    do_reset();
    send(8'd66); ms(20);
    send(8'd0); ms(50);
    check("R8 trip stays latched", 1'b1);
    do_reset();
    check("R9 reset clears latched trip", 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset_R9();
    test_below_R1();
    test_tier(8'd12,  125, "R3 tier 1 lower edge");
    test_tier(8'd19,  125, "R2 tier 1 upper edge");
    test_tier(8'd40,   50, "R2 tier 5");
    test_tier(8'd66,   20, "R3 tier 9");
    test_tier(8'd255,  20, "R2 full scale");
    test_cut_R4();
    test_no_lengthen_R5();
    test_clear_R6();
    test_sat_R7();
    test_latch_R8();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule